// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels may use the transfer engine next. Each channel raises a request line. A 2-bit mode input picks one of three fixed priority permutations or a rotating scheme. The winning channel receives a registered one-hot grant. That grant stays in place until the engine signals, with a single-cycle pulse, that one transfer unit on that channel has finished.

In rotating mode the arbiter keeps a ranking of the four channels. At each completed unit the serviced channel drops to the bottom of the ranking. If no other channel is asking for service at that moment, the ranking returns to its initial order instead. The fixed permutations are not simple ascending orders, so a channel with a higher number can outrank a channel with a lower number. The stored ranking is kept while a fixed mode is active and is used again when rotating mode returns.

Top module: `dma_chan_arbiter`

## Requirements
- R1: During and after a synchronous active-high reset, `grant_o` is 4'b0000 and `grant_valid_o` is low. The rotating ranking is set to channel 0, 1, 2, 3 (highest first).
- R2: `grant_o` is always one-hot or zero, and `grant_valid_o` equals the OR of the bits of `grant_o`. With no requests pending at an arbitration edge, the grant stays zero.
- R3: Mode 2'b00 ranks channels 0 > 1 > 2 > 3. Bit n of `req_i` and of `grant_o` belongs to channel n.
- R4: Mode 2'b01 ranks channels 0 > 2 > 3 > 1.
- R5: Mode 2'b10 ranks channels 2 > 0 > 1 > 3.
- R6: While a grant is active and `unit_done_i` is low, `grant_o` holds its value at every edge, whatever `req_i` and `mode_i` do.
- R7: A clock edge with a grant active and `unit_done_i` high clears the grant. Any clock edge with no grant active loads the winner among the requests present at that edge, so a new grant appears one edge after the release.
- R8: Right after reset, mode 2'b11 (rotating) ranks channels 0 > 1 > 2 > 3.
- R9: In mode 2'b11, an edge that ends a unit while another channel is requesting moves the serviced channel to the lowest rank. The other three channels move up one place and keep their relative order.
- R10: In mode 2'b11, an edge that ends a unit while no channel other than the serviced one is requesting sets the ranking back to 0 > 1 > 2 > 3.
- R11: In modes 2'b00, 2'b01 and 2'b10 the rotating ranking is not changed, not even by completed units. Returning to 2'b11 resumes with the stored ranking.
- R12: A `unit_done_i` pulse at an edge with no grant active changes neither the grant nor the rotating ranking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 4 | Request line per channel, bit n for channel n |
| mode_i | input | 2 | 00/01/10 fixed permutations, 11 rotating |
| unit_done_i | input | 1 | Pulse: the granted channel finished one transfer unit |
| grant_o | output | 4 | One-hot grant, bit n for channel n |
| grant_valid_o | output | 1 | High while a grant is active |

## Verification
The hardest situation to reach from the ports is the fallback of the rotating ranking. It needs mode 11, a ranking that has already been rotated away from its initial order, and a unit completion at which only the serviced channel is still requesting. Random request patterns rarely hit this combination. A directed sequence therefore rotates the ranking several times and then ends a unit with only the serviced channel's request high. The ranking after that edge (fallback or demotion) shows up in which channel wins the next all-request arbitration. Seeded random cycles that mix modes, sparse requests and stray completion pulses run alongside a bench model and catch ordering errors across mode switches.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_CH = 4;
    localparam int ID_W   = $clog2(NUM_CH);

    typedef logic [ID_W-1:0]            ch_id_t;
    typedef ch_id_t [NUM_CH-1:0]        order_t;   // index 0 = highest rank
    typedef logic [NUM_CH-1:0]          ch_vec_t;

    typedef enum logic [1:0] {
        MODE_FIX_A  = 2'b00,
        MODE_FIX_B  = 2'b01,
        MODE_FIX_C  = 2'b10,
        MODE_ROTATE = 2'b11
    } arb_mode_e;

    function automatic order_t home_order();
        order_t r;
        for (int p = 0; p < NUM_CH; p++) r[p] = ch_id_t'(p);
        return r;
    endfunction

    function automatic order_t fixed_order(arb_mode_e m);
        order_t r;
        case (m)
            MODE_FIX_B: begin r[0] = 2'd0; r[1] = 2'd2; r[2] = 2'd3; r[3] = 2'd1; end
            MODE_FIX_C: begin r[0] = 2'd2; r[1] = 2'd0; r[2] = 2'd1; r[3] = 2'd3; end
            default:    r = home_order();
        endcase
        return r;
    endfunction

    // Move channel c to the bottom; the rest shift up in their order.
    function automatic order_t demote(order_t o, ch_id_t c);
        order_t       r;
        logic [ID_W:0] w;
        r = o;
        w = '0;
        for (int p = 0; p < NUM_CH; p++) begin
            if (o[p] != c) begin
                r[w[ID_W-1:0]] = o[p];
                w = w + 1'b1;
            end
        end
        r[NUM_CH-1] = c;
        return r;
    endfunction

    function automatic ch_vec_t pick(ch_vec_t rq, order_t o);
        ch_vec_t g;
        logic    found;
        g     = '0;
        found = 1'b0;
        for (int p = 0; p < NUM_CH; p++) begin
            if (!found && rq[o[p]]) begin
                g[o[p]] = 1'b1;
                found   = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic ch_id_t onehot_id(ch_vec_t v);
        ch_id_t id;
        id = '0;
        for (int n = 0; n < NUM_CH; n++) if (v[n]) id = ch_id_t'(n);
        return id;
    endfunction

endpackage

// File: rtl/arb_prio_select.sv
module arb_prio_select
    import arb_pkg::*;
(
    input  arb_mode_e mode,
    input  order_t    rr_order,
    input  ch_vec_t   req,
    output ch_vec_t   winner
);
    order_t eff_order;

    always_comb begin
        eff_order = (mode == MODE_ROTATE) ? rr_order : fixed_order(mode);
        winner    = pick(req, eff_order);
    end

    always_comb begin
        assert_winner_subset_R2: assert ((winner & ~req) == '0);
    end
endmodule

// File: rtl/arb_rr_order.sv
module arb_rr_order
    import arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rr_en,
    input  logic    unit_done,
    input  ch_vec_t req,
    input  ch_vec_t grant,
    output order_t  order_q
);
    logic    unit_end;
    logic    others_idle;
    ch_vec_t present;

    assign unit_end    = rr_en && unit_done && (grant != '0);
    assign others_idle = ((req & ~grant) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            order_q <= home_order();
        end else if (unit_end) begin
            order_q <= others_idle ? home_order() : demote(order_q, onehot_id(grant));
        end
    end

    always_comb begin
        present = '0;
        for (int p = 0; p < NUM_CH; p++) present[order_q[p]] = 1'b1;
    end

    assert_perm_R9: assert property (@(posedge clk) disable iff (rst)
        present == '1);
    assert_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        !rr_en |=> $stable(order_q));
    assert_idle_done_R12: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |=> $stable(order_q));
    assert_fallback_R10: assert property (@(posedge clk) disable iff (rst)
        (rr_en && unit_done && grant != '0 && (req & ~grant) == '0)
        |=> order_q == home_order());
    assert_demote_R9: assert property (@(posedge clk) disable iff (rst)
        (rr_en && unit_done && grant != '0 && (req & ~grant) != '0)
        |=> order_q[NUM_CH-1] == $past(onehot_id(grant)));
endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold
    import arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    unit_done,
    input  ch_vec_t req,
    input  ch_vec_t winner,
    output ch_vec_t grant_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if (grant_q == '0) begin
            grant_q <= winner;
        end else if (unit_done) begin
            grant_q <= '0;
        end
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && !unit_done) |=> $stable(grant_q));
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && unit_done) |=> grant_q == '0);
    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0 && req != '0) |=> grant_q != '0);
    assert_from_req_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0) |=> (grant_q & ~$past(req)) == '0);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [1:0]        mode_i,
    input  logic              unit_done_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic              grant_valid_o
);
    arb_mode_e mode;
    order_t    rr_order;
    ch_vec_t   winner;
    ch_vec_t   grant;

    assign mode = arb_mode_e'(mode_i);

    arb_prio_select u_select (
        .mode     (mode),
        .rr_order (rr_order),
        .req      (req_i),
        .winner   (winner)
    );

    arb_grant_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .unit_done (unit_done_i),
        .req       (req_i),
        .winner    (winner),
        .grant_q   (grant)
    );

    arb_rr_order u_order (
        .clk       (clk),
        .rst       (rst),
        .rr_en     (mode == MODE_ROTATE),
        .unit_done (unit_done_i),
        .req       (req_i),
        .grant     (grant),
        .order_q   (rr_order)
    );

    assign grant_o       = grant;
    assign grant_valid_o = |grant;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (grant_o == '0 && !grant_valid_o));
endmodule

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] req;
    logic [1:0] mode;
    logic       done;
    logic [3:0] grant_o;
    logic       grant_valid_o;

    int tests = 0;
    int fails = 0;

    logic [3:0] m_grant;
    int         m_ord[$];

    always #10 clk = ~clk;

    dma_chan_arbiter i_dma_chan_arbiter (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req),
        .mode_i        (mode),
        .unit_done_i   (done),
        .grant_o       (grant_o),
        .grant_valid_o (grant_valid_o)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_pick(logic [3:0] rq, logic [1:0] md);
        int seq[4];
        case (md)
            2'b00: seq = '{0, 1, 2, 3};
            2'b01: seq = '{0, 2, 3, 1};
            2'b10: seq = '{2, 0, 1, 3};
            default: for (int k = 0; k < 4; k++) seq[k] = m_ord[k];
        endcase
        for (int k = 0; k < 4; k++)
            if (rq[seq[k]]) return 4'b0001 << seq[k];
        return 4'b0000;
    endfunction

    function automatic int id_of(logic [3:0] g);
        for (int k = 0; k < 4; k++) if (g[k]) return k;
        return 0;
    endfunction

    task automatic model_home();
        m_ord = '{0, 1, 2, 3};
    endtask

    // Drive one cycle, advance model, compare after the edge.
    task automatic step(input logic [3:0] rq, input logic [1:0] md, input logic dn);
        string tag;
        req = rq; mode = md; done = dn;
        if (m_grant == 4'b0000) begin
            case (md)
                2'b00: tag = "R3";
                2'b01: tag = "R4";
                2'b10: tag = "R5";
                default: tag = "R9";
            endcase
            if (dn) tag = {tag, "/R12"};
            m_grant = model_pick(rq, md);
        end else if (dn) begin
            tag = (md == 2'b11) ? "R7/R9" : "R7/R11";
            if (md == 2'b11) begin
                if ((rq & ~m_grant) == 4'b0000) begin
                    model_home();
                    tag = "R7/R10";
                end else begin
                    int c;
                    c = id_of(m_grant);
                    for (int k = 0; k < m_ord.size(); k++)
                        if (m_ord[k] == c) begin m_ord.delete(k); break; end
                    m_ord.push_back(c);
                end
            end
            m_grant = 4'b0000;
        end else begin
            tag = "R6";
        end
        @(posedge clk);
        @(negedge clk);
        check(grant_o, m_grant, tag);
        check({3'b000, grant_valid_o}, {3'b000, |m_grant}, "R2 valid");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; req = 4'b1111; mode = 2'b11; done = 1'b1;
        m_grant = 4'b0000;
        model_home();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(grant_o, 4'b0000, "R1 grant in reset");
        check({3'b000, grant_valid_o}, 4'b0000, "R1 valid in reset");
        rst = 1'b0;

        // R8 home ranking, then R9 rotation
        step(4'b1111, 2'b11, 1'b0); check(grant_o, 4'b0001, "R8");
        step(4'b1111, 2'b11, 1'b1);
        step(4'b1111, 2'b11, 1'b0); check(grant_o, 4'b0010, "R9 after one demote");
        step(4'b1111, 2'b11, 1'b1);
        step(4'b1011, 2'b11, 1'b0); check(grant_o, 4'b1000, "R9 order 2,3,0,1");
        step(4'b1011, 2'b11, 1'b1);
        step(4'b1011, 2'b11, 1'b0); check(grant_o, 4'b0001, "R9 order 2,0,1,3");
        // R10: only the serviced channel requests at completion
        step(4'b0001, 2'b11, 1'b1);
        step(4'b1111, 2'b11, 1'b0); check(grant_o, 4'b0001, "R10 fallback");
        // R11: fixed mode leaves ranking alone
        step(4'b1111, 2'b11, 1'b1);
        step(4'b1111, 2'b00, 1'b0); check(grant_o, 4'b0001, "R11 fixed mode");
        step(4'b1111, 2'b00, 1'b1);
        step(4'b1111, 2'b00, 1'b0);
        step(4'b1111, 2'b00, 1'b1);
        step(4'b1111, 2'b11, 1'b0); check(grant_o, 4'b0010, "R11 resume stored");
        // R12: stray completion with no grant
        step(4'b1111, 2'b11, 1'b1);
        step(4'b0000, 2'b11, 1'b1); check(grant_o, 4'b0000, "R12 no grant");
        step(4'b0000, 2'b11, 1'b1);
        step(4'b1111, 2'b11, 1'b0); check(grant_o, 4'b0100, "R12 ranking kept");
        step(4'b1111, 2'b11, 1'b1);
        // fixed permutations
        step(4'b1010, 2'b01, 1'b0); check(grant_o, 4'b1000, "R4 ch3 over ch1");
        step(4'b1010, 2'b01, 1'b1);
        step(4'b0011, 2'b10, 1'b0); check(grant_o, 4'b0001, "R5 ch0 over ch1");
        step(4'b0011, 2'b10, 1'b1);
        step(4'b1111, 2'b10, 1'b0); check(grant_o, 4'b0100, "R5 ch2 first");
        // R6 hold against changing inputs
        step(4'b0000, 2'b00, 1'b0); check(grant_o, 4'b0100, "R6 hold");
        step(4'b1011, 2'b01, 1'b0); check(grant_o, 4'b0100, "R6 hold");
        step(4'b1011, 2'b01, 1'b1); check(grant_o, 4'b0000, "R7 release");
        step(4'b1100, 2'b00, 1'b0); check(grant_o, 4'b0100, "R3 ch2 over ch3");
        step(4'b1100, 2'b00, 1'b1);
        step(4'b0000, 2'b00, 1'b0); check(grant_o, 4'b0000, "R2 idle");

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] rq;
            logic [1:0] md;
            logic       dn;
            rq = ($urandom_range(0, 2) == 0) ? (4'b0001 << $urandom_range(0, 3))
                                             : 4'($urandom_range(0, 15));
            md = ($urandom_range(0, 9) < 6) ? 2'b11 : 2'($urandom_range(0, 2));
            dn = ($urandom_range(0, 2) == 0);
            step(rq, md, dn);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule